// File: doc/BRIEF.md
# Vector Inner-Product Engine

This block carries out a single dot-product instruction on two vectors held in memory. The instruction gives an opcode, two source base addresses, a destination address and an element count. Once it is accepted, the engine reads one pair of elements per clock, one from each of two synchronous read ports. It passes each pair through a multiplier with a parameterised number of register stages, and a running-sum adder adds the product to an accumulator. When the last product has left both pipelines, the engine writes the sum to the destination address in a single write cycle.

Control uses a plain start / busy / done handshake. The memory ports are plain as well. Each read port returns its data exactly one clock after the read enable and cannot stall. The write port takes its data in the single cycle that write enable is high. None of these ports has back-pressure, so the memories attached to the engine must keep to this fixed timing.

Top module: `vip_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `rd_en` and `wr_en` are all low.
- R2: A `start` pulse in a cycle where `busy` is low and `instr_op` equals 4'hA is accepted. `busy` is high from the next cycle until the write has completed, and there are no reads or writes while `busy` is low.
- R3: For a length of n, exactly n read cycles follow, with no gaps between them. Read k (k = 0..n-1) presents `instr_src1 + k` on `rd_addr_a` and `instr_src2 + k` on `rd_addr_b`, both wrapping modulo 2^ADDR_W.
- R4: The written value is the sum of a_k * b_k, where each element is a DATA_W-bit signed two's-complement number. The sum is kept modulo 2^ACC_W. It is written to the `instr_dst` address in exactly one `wr_en` cycle.
- R5: For a nonzero length, `wr_en` rises exactly MUL_STAGES + 2 cycles after the last read cycle, and no product is still in flight at that point.
- R6: `done` is a one-cycle pulse in the cycle right after `wr_en`, and `busy` is low in that same cycle.
- R7: A length of zero causes no reads and writes zero to `instr_dst`. `wr_en` is high in the first cycle after acceptance.
- R8: A `start` that arrives while `busy` is high has no effect. The running instruction keeps its addresses, its read count and its result.
- R9: A `start` carrying any opcode other than 4'hA is ignored: `busy` stays low and no read or write takes place.
- R10: The accumulator is cleared when an instruction is accepted, so a result never carries over any part of the previous instruction's sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Instruction request |
| instr_op | input | 4 | Opcode; 4'hA selects inner product |
| instr_src1 | input | ADDR_W | Base address of vector A |
| instr_src2 | input | ADDR_W | Base address of vector B |
| instr_dst | input | ADDR_W | Result address |
| instr_len | input | LEN_W | Element count |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_en | output | 1 | Read strobe for both source ports |
| rd_addr_a | output | ADDR_W | Read address, vector A |
| rd_addr_b | output | ADDR_W | Read address, vector B |
| rd_data_a | input | DATA_W | Read data A, one cycle after rd_en |
| rd_data_b | input | DATA_W | Read data B, one cycle after rd_en |
| wr_en | output | 1 | Result write strobe |
| wr_addr | output | ADDR_W | Result write address |
| wr_data | output | ACC_W | Result value |

## Verification
The vector table covers lengths of 1, 3, 5, 16 and 200 with mixed-sign operands. One entry's bases straddle the top of the address space, which separates correct modulo wrap from a saturating or carrying pointer. Running the table back to back shows whether the accumulator is cleared between instructions. It also catches any off-by-one in the read count or the drain wait, because the write cycle is checked against the last read. Directed cases cover a zero length, a foreign opcode, and a start that is pulsed in the middle of a run. These three separate the ignore paths from a restart.

// File: rtl/vip_pkg.sv
package vip_pkg;
  localparam int OP_W = 4;
  localparam logic [OP_W-1:0] OP_DOT = 4'hA;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_DRAIN = 2'd2,
    ST_WRITE = 2'd3
  } vip_state_e;
endpackage

// File: rtl/vip_ctrl.sv
module vip_ctrl
  import vip_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 8,
  parameter int MUL_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   op,
  input  logic [ADDR_W-1:0] src1,
  input  logic [ADDR_W-1:0] src2,
  input  logic [ADDR_W-1:0] dst,
  input  logic [LEN_W-1:0]  len,
  output logic              busy,
  output logic              done,
  output logic              acc_clr,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr_a,
  output logic [ADDR_W-1:0] rd_addr_b,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr
);
  // one read-latency cycle plus the multiplier stages before the sum settles
  localparam int DRAIN_CYC = MUL_STAGES + 1;
  localparam int DCNT_W    = $clog2(DRAIN_CYC + 1);

  vip_state_e        state;
  logic [ADDR_W-1:0] ptr_a, ptr_b, dst_q;
  logic [LEN_W-1:0]  remain;
  logic [DCNT_W-1:0] drain_cnt;
  logic              accept;

  assign accept = (state == ST_IDLE) && start && (op == OP_DOT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ptr_a     <= '0;
      ptr_b     <= '0;
      dst_q     <= '0;
      remain    <= '0;
      drain_cnt <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          ptr_a  <= src1;
          ptr_b  <= src2;
          dst_q  <= dst;
          remain <= len;
          state  <= (len == '0) ? ST_WRITE : ST_ISSUE;
        end
        ST_ISSUE: begin
          ptr_a  <= ptr_a + 1'b1;
          ptr_b  <= ptr_b + 1'b1;
          remain <= remain - 1'b1;
          if (remain == LEN_W'(1)) begin
            state     <= ST_DRAIN;
            drain_cnt <= DCNT_W'(DRAIN_CYC - 1);
          end
        end
        ST_DRAIN: begin
          if (drain_cnt == '0) state <= ST_WRITE;
          else drain_cnt <= drain_cnt - 1'b1;
        end
        ST_WRITE: begin
          state <= ST_IDLE;
          done  <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy      = (state != ST_IDLE);
  assign acc_clr   = accept;
  assign rd_en     = (state == ST_ISSUE);
  assign rd_addr_a = ptr_a;
  assign rd_addr_b = ptr_b;
  assign wr_en     = (state == ST_WRITE);
  assign wr_addr   = dst_q;

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en && $past(rd_en) |-> rd_addr_a == $past(rd_addr_a) + 1'b1); // R3
  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_en && !wr_en); // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_WR_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> done && !busy); // R6
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    busy && start |=> $stable(wr_addr)); // R8
endmodule

// File: rtl/vip_mul_pipe.sv
module vip_mul_pipe #(
  parameter int DATA_W = 16,
  parameter int STAGES = 2,
  localparam int PROD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              out_valid,
  output logic [PROD_W-1:0] prod
);
  logic [PROD_W-1:0] prod_q [STAGES];
  logic              vld_q  [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prod_q[0] <= '0;
          vld_q[0]  <= 1'b0;
        end else begin
          prod_q[0] <= PROD_W'($signed(a) * $signed(b));
          vld_q[0]  <= in_valid;
        end
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          prod_q[s] <= '0;
          vld_q[s]  <= 1'b0;
        end else begin
          prod_q[s] <= prod_q[s-1];
          vld_q[s]  <= vld_q[s-1];
        end
      end
    end
  end

  assign prod      = prod_q[STAGES-1];
  assign out_valid = vld_q[STAGES-1];
endmodule

// File: rtl/vip_accum.sv
module vip_accum #(
  parameter int PROD_W = 32,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [PROD_W-1:0] prod,
  output logic [ACC_W-1:0]  acc
);
  logic [ACC_W-1:0] prod_ext;
  assign prod_ext = {{(ACC_W - PROD_W){prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        acc <= '0;
    else if (clr)      acc <= '0;
    else if (in_valid) acc <= acc + prod_ext;
  end

  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> acc == '0); // R10
endmodule

// File: rtl/vip_engine.sv
module vip_engine
  import vip_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int ADDR_W     = 8,
  parameter int LEN_W      = 8,
  parameter int ACC_W      = 40,
  parameter int MUL_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [OP_W-1:0]   instr_op,
  input  logic [ADDR_W-1:0] instr_src1,
  input  logic [ADDR_W-1:0] instr_src2,
  input  logic [ADDR_W-1:0] instr_dst,
  input  logic [LEN_W-1:0]  instr_len,
  output logic              busy,
  output logic              done,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr_a,
  output logic [ADDR_W-1:0] rd_addr_b,
  input  logic [DATA_W-1:0] rd_data_a,
  input  logic [DATA_W-1:0] rd_data_b,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [ACC_W-1:0]  wr_data
);
  localparam int PROD_W = 2 * DATA_W;

  logic              acc_clr, mem_vld, prod_vld;
  logic [PROD_W-1:0] prod;

  vip_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MUL_STAGES(MUL_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .op(instr_op),
    .src1(instr_src1), .src2(instr_src2), .dst(instr_dst), .len(instr_len),
    .busy(busy), .done(done), .acc_clr(acc_clr),
    .rd_en(rd_en), .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b),
    .wr_en(wr_en), .wr_addr(wr_addr)
  );

  // read data is valid one cycle after the strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_vld <= 1'b0;
    else        mem_vld <= rd_en;
  end

  vip_mul_pipe #(.DATA_W(DATA_W), .STAGES(MUL_STAGES)) u_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(mem_vld),
    .a(rd_data_a), .b(rd_data_b), .out_valid(prod_vld), .prod(prod)
  );

  vip_accum #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .clr(acc_clr), .in_valid(prod_vld),
    .prod(prod), .acc(wr_data)
  );

  AST_WR_DRAINED: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !mem_vld && !prod_vld); // R5
  AST_WR_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> busy && !rd_en); // R4
endmodule

// File: tb/tb_vip_engine.sv
module tb_vip_engine;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 8;
  localparam int LEN_W  = 8;
  localparam int ACC_W  = 40;
  localparam int MUL_ST = 2;
  localparam logic [3:0] OP_DOT = 4'hA;

  // {src1, src2, dst, len}
  localparam int NVEC = 6;
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h10, 8'h40, 8'h01, 8'd1},
    {8'h00, 8'h80, 8'h02, 8'd5},
    {8'h20, 8'h25, 8'h03, 8'd16},
    {8'hFC, 8'hFA, 8'h04, 8'd8},
    {8'h05, 8'h33, 8'h05, 8'd200},
    {8'h90, 8'h07, 8'h06, 8'd3}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [3:0] instr_op = '0;
  logic [ADDR_W-1:0] instr_src1 = '0, instr_src2 = '0, instr_dst = '0;
  logic [LEN_W-1:0] instr_len = '0;
  logic busy, done, rd_en, wr_en;
  logic [ADDR_W-1:0] rd_addr_a, rd_addr_b, wr_addr;
  logic [DATA_W-1:0] rd_data_a = '0, rd_data_b = '0;
  logic [ACC_W-1:0] wr_data;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  vip_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W),
               .ACC_W(ACC_W), .MUL_STAGES(MUL_ST)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .instr_op(instr_op),
    .instr_src1(instr_src1), .instr_src2(instr_src2), .instr_dst(instr_dst),
    .instr_len(instr_len), .busy(busy), .done(done), .rd_en(rd_en),
    .rd_addr_a(rd_addr_a), .rd_addr_b(rd_addr_b), .rd_data_a(rd_data_a),
    .rd_data_b(rd_data_b), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  function automatic logic signed [15:0] aval(int i);
    return 16'(i * 37 - 2000);
  endfunction
  function automatic logic signed [15:0] bval(int i);
    return 16'(1500 - i * 53);
  endfunction

  // memory model: data one cycle after the strobe
  always @(posedge clk) begin
    if (rd_en) begin
      rd_data_a <= aval(int'(rd_addr_a));
      rd_data_b <= bval(int'(rd_addr_b));
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_instr(input logic [7:0] s1, input logic [7:0] s2,
                           input logic [7:0] d, input logic [7:0] n,
                           input bit poke, input string tag);
    longint exp_sum = 0;
    int nrd = 0, addr_err = 0, wr_cnt = 0, wr_c = -1, last_rd = -1, done_c = -1;
    int busy_err = 0;
    logic [ACC_W-1:0] wdata = '0;
    logic [7:0] waddr = '0;
    for (int k = 0; k < int'(n); k++)
      exp_sum += longint'(aval(int'(8'(s1 + k)))) * longint'(bval(int'(8'(s2 + k))));
    @(negedge clk);
    start = 1'b1; instr_op = OP_DOT;
    instr_src1 = s1; instr_src2 = s2; instr_dst = d; instr_len = n;
    @(negedge clk);
    start = 1'b0;
    for (int c = 1; c < 1000; c++) begin
      if (poke && c == 2) begin
        start = 1'b1; instr_op = OP_DOT;
        instr_src1 = 8'h77; instr_src2 = 8'h11; instr_dst = 8'hEE; instr_len = 8'd9;
      end
      if (poke && c == 3) start = 1'b0;
      if (rd_en) begin
        if (rd_addr_a != 8'(s1 + nrd) || rd_addr_b != 8'(s2 + nrd)) addr_err++;
        nrd++;
        last_rd = c;
      end
      if (wr_en) begin
        wr_cnt++; wr_c = c; wdata = wr_data; waddr = wr_addr;
      end
      if (done) begin
        done_c = c;
        if (busy) busy_err++;
        break;
      end
      if (!busy) busy_err++;
      @(negedge clk);
    end
    check(nrd == int'(n), {tag, " R3 read count"}, nrd, n);
    check(addr_err == 0, {tag, " R3 addresses"}, addr_err, 0);
    check(wr_cnt == 1 && waddr == d, {tag, " R4 write addr"}, waddr, d);
    check(wdata == exp_sum[ACC_W-1:0], {tag, " R4 R10 result"},
          longint'($signed(wdata)), exp_sum);
    if (n == 0)
      check(wr_c == 1, {tag, " R7 write cycle"}, wr_c, 1);
    else
      check(wr_c == last_rd + MUL_ST + 2, {tag, " R5 write timing"}, wr_c, last_rd + MUL_ST + 2);
    check(done_c == wr_c + 1 && busy_err == 0, {tag, " R2 R6 busy/done"}, done_c, wr_c + 1);
    @(negedge clk);
    check(!done && !busy, {tag, " R6 done pulse"}, done, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!busy && !done && !rd_en && !wr_en, "R1 in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!busy && !done && !rd_en && !wr_en, "R1 after reset", busy, 0);

    // table of vectors, run back to back (R10: accumulator cleared each time)
    for (int v = 0; v < NVEC; v++)
      run_instr(VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0], 1'b0, $sformatf("vec%0d", v));

    // R7 zero length
    run_instr(8'h30, 8'h31, 8'h55, 8'd0, 1'b0, "zero-len");

    // R8 start while busy ignored
    run_instr(8'h08, 8'h18, 8'h66, 8'd6, 1'b1, "poke");

    // R9 foreign opcode ignored
    begin
      int bad = 0;
      @(negedge clk);
      start = 1'b1; instr_op = 4'h3; instr_len = 8'd4; instr_dst = 8'h99;
      @(negedge clk);
      start = 1'b0;
      for (int c = 0; c < 6; c++) begin
        if (busy || rd_en || wr_en || done) bad++;
        @(negedge clk);
      end
      check(bad == 0, "R9 foreign opcode", bad, 0);
    end

    // R10 result after the ignored request still matches a fresh sum
    run_instr(8'hA0, 8'h0B, 8'h07, 8'd4, 1'b0, "after-ignore");

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule